// File: doc/BRIEF.md
# Banked Privileged Scratch Register Controller

This block holds a 32-bit scratch word that system software uses to tag the running thread. It is visible only to privileged code, and it keeps separate secure and non-secure copies. It sits behind a coprocessor-style access decoder. Each cycle it may receive one decoded move-to or move-from request, made up of five encoding fields, a write flag and write data. It also receives the current privilege level (0 to 3), the non-secure bit, and static inputs that describe how the hypervisor level (level 2) and the monitor level (level 3) are configured.

For a request whose encoding matches, the block grants the access, reports an undefined instruction, or reports a trap to the hypervisor level with a syndrome code. Two trap outputs exist: one for when the hypervisor level runs in 64-bit state, and one for when it runs in 32-bit state. On a granted access, the block chooses which copy to use from the privilege level, the non-secure bit and whether the monitor level is implemented in 32-bit state. When no banking applies, the single copy is kept in the non-secure storage. Only software writes change the copies. Their contents after reset carry no meaning.

Results are registered and appear as single-cycle pulses in the cycle after the request. Requests may be issued back to back.

Top module: `tidb_ctrl`

## Requirements
- R1: Only a request with coprocessor field 0xF, opc1 0x0, CRn 0xD, CRm 0x0 and opc2 0x4 is served. Any other request gives no response pulse and changes neither copy.
- R2: A matching request at privilege level 0 raises `undef_flt` and changes neither copy.
- R3: At level 1, when `hyp_en` and `hyp_trap13` are both 1, the access traps and changes neither copy. `trap64` fires when `hyp_aa64` is 1, otherwise `trap32` fires. Either way `syndrome` is 0x03.
- R4: At level 1 with no trap: if `mon_impl` and `mon_aa32` are both 1, `ns_bit` 0 selects the secure copy and `ns_bit` 1 selects the non-secure copy. Otherwise the non-secure copy, which acts as the single copy, is used.
- R5: At level 2 the non-secure copy is always used, and the secure copy is never written.
- R6: At level 3, `ns_bit` 0 selects the secure copy and `ns_bit` 1 selects the non-secure copy.
- R7: Each request produces, one cycle later, a single-cycle pulse on exactly one of `done`, `undef_flt`, `trap64`, `trap32`. All four are low on cycles that follow no request.
- R8: `syndrome` is 0 on every cycle without a trap pulse. `rdata` equals the selected copy with `done` for a read, and is 0 otherwise.
- R9: A copy changes only on a granted write to it. A read in the very next cycle returns the value just written.
- R10: While reset is asserted, and after it is released, all outputs are low until a request arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = move to register, 0 = move from register |
| req_cp | input | 4 | Coprocessor field |
| req_op1 | input | 3 | opc1 field |
| req_crn | input | 4 | CRn field |
| req_crm | input | 4 | CRm field |
| req_op2 | input | 3 | opc2 field |
| req_wdata | input | 32 | Write data |
| cur_el | input | 2 | Current privilege level |
| ns_bit | input | 1 | Non-secure state bit |
| hyp_en | input | 1 | Hypervisor level enabled |
| hyp_aa64 | input | 1 | Hypervisor level runs in 64-bit state |
| hyp_trap13 | input | 1 | Hypervisor trap control for CRn 13 |
| mon_impl | input | 1 | Monitor level implemented |
| mon_aa32 | input | 1 | Monitor level runs in 32-bit state |
| done | output | 1 | Access granted pulse |
| rdata | output | 32 | Read data, valid with `done` for a read |
| undef_flt | output | 1 | Undefined instruction pulse |
| trap64 | output | 1 | Trap to a 64-bit hypervisor level |
| trap32 | output | 1 | Trap to a 32-bit hypervisor level |
| syndrome | output | 8 | Trap syndrome code |

## Verification
The assertions check these properties on every cycle:
- the four response pulses are mutually exclusive, and the syndrome matches the trap pulses;
- a non-matching request stays silent;
- a level-0 access faults;
- neither copy moves without a granted write, and faulting or level-2 writes leave the secure copy alone.

Bank selection is shown only by the bench's scenarios, which write through one privilege and banking configuration and read back through another. These cover the mapping of the single copy onto non-secure storage, the choice between the two trap outputs, and back-to-back write-then-read.

// File: rtl/tidb_pkg.sv
package tidb_pkg;

  // Outcome of one decoded access
  typedef enum logic [2:0] {
    ACC_NONE   = 3'd0,
    ACC_DONE   = 3'd1,
    ACC_UNDEF  = 3'd2,
    ACC_TRAP64 = 3'd3,
    ACC_TRAP32 = 3'd4
  } acc_kind_e;

  // Physical copy index; the unbanked copy lives in BANK_NSEC
  typedef enum logic {
    BANK_SEC  = 1'b0,
    BANK_NSEC = 1'b1
  } bank_e;

  localparam int unsigned NUM_BANKS = 2;
  localparam int unsigned EL_W      = 2;

endpackage

// File: rtl/tidb_decode.sv
module tidb_decode #(
  parameter int unsigned    CP_W    = 4,
  parameter int unsigned    OP1_W   = 3,
  parameter int unsigned    CRN_W   = 4,
  parameter int unsigned    CRM_W   = 4,
  parameter int unsigned    OP2_W   = 3,
  parameter logic [CP_W-1:0]  CP_VAL  = 4'hF,
  parameter logic [OP1_W-1:0] OP1_VAL = 3'h0,
  parameter logic [CRN_W-1:0] CRN_VAL = 4'hD,
  parameter logic [CRM_W-1:0] CRM_VAL = 4'h0,
  parameter logic [OP2_W-1:0] OP2_VAL = 3'h4
) (
  input  logic [CP_W-1:0]  cp,
  input  logic [OP1_W-1:0] op1,
  input  logic [CRN_W-1:0] crn,
  input  logic [CRM_W-1:0] crm,
  input  logic [OP2_W-1:0] op2,
  output logic             hit
);

  localparam int unsigned NFIELD = 5;

  logic [NFIELD-1:0] field_ok;

  always_comb begin
    field_ok[0] = (cp  == CP_VAL);
    field_ok[1] = (op1 == OP1_VAL);
    field_ok[2] = (crn == CRN_VAL);
    field_ok[3] = (crm == CRM_VAL);
    field_ok[4] = (op2 == OP2_VAL);
    hit         = &field_ok;
  end

endmodule

// File: rtl/tidb_policy.sv
module tidb_policy
  import tidb_pkg::*;
(
  input  logic [EL_W-1:0] el,
  input  logic            ns_bit,
  input  logic            hyp_en,
  input  logic            hyp_aa64,
  input  logic            hyp_trap13,
  input  logic            mon_impl,
  input  logic            mon_aa32,
  output acc_kind_e       kind,
  output bank_e           bank
);

  logic  banked;
  bank_e ns_sel;

  always_comb begin
    banked = mon_impl && mon_aa32;
    ns_sel = ns_bit ? BANK_NSEC : BANK_SEC;
    kind   = ACC_DONE;
    bank   = BANK_NSEC;
    unique case (el)
      2'd0: kind = ACC_UNDEF;
      2'd1: begin
        if (hyp_en && hyp_trap13) begin
          kind = hyp_aa64 ? ACC_TRAP64 : ACC_TRAP32;
        end else if (banked) begin
          bank = ns_sel;
        end else begin
          bank = BANK_NSEC;
        end
      end
      2'd2: bank = BANK_NSEC;
      default: bank = ns_sel;
    endcase
  end

endmodule

// File: rtl/tidb_bank.sv
module tidb_bank
  import tidb_pkg::*;
#(
  parameter int unsigned        DATA_W  = 32,
  parameter logic [DATA_W-1:0]  RST_VAL = DATA_W'(32'hDEAD_BEEF)
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_en,
  input  bank_e                               wr_bank,
  input  logic [DATA_W-1:0]                   wr_data,
  input  bank_e                               rd_bank,
  output logic [DATA_W-1:0]                   rd_data,
  output logic [NUM_BANKS-1:0][DATA_W-1:0]    copy_q
);

  logic [NUM_BANKS-1:0]             copy_en;
  logic [NUM_BANKS-1:0][DATA_W-1:0] copy_d;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_copy
    localparam bank_e THIS_BANK = bank_e'(b);

    assign copy_en[b] = wr_en && (wr_bank == THIS_BANK);
    assign copy_d[b]  = wr_data;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        copy_q[b] <= RST_VAL;
      end else if (copy_en[b]) begin
        copy_q[b] <= copy_d[b];
      end
    end
  end

  assign rd_data = copy_q[rd_bank];

  // R9
  copy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(copy_q));

  // R9
  other_copy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_bank == BANK_SEC) |=> $stable(copy_q[BANK_NSEC]));

endmodule

// File: rtl/tidb_ctrl.sv
module tidb_ctrl
  import tidb_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SYN_W  = 8,
  parameter logic [SYN_W-1:0] SYN_HYP = 8'h03
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [3:0]        req_cp,
  input  logic [2:0]        req_op1,
  input  logic [3:0]        req_crn,
  input  logic [3:0]        req_crm,
  input  logic [2:0]        req_op2,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        cur_el,
  input  logic              ns_bit,
  input  logic              hyp_en,
  input  logic              hyp_aa64,
  input  logic              hyp_trap13,
  input  logic              mon_impl,
  input  logic              mon_aa32,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              undef_flt,
  output logic              trap64,
  output logic              trap32,
  output logic [SYN_W-1:0]  syndrome
);

  localparam int unsigned RST_STAGES = 2;

  // Reset: asserted asynchronously, released on a clock edge
  logic [RST_STAGES-1:0] rst_pipe;
  logic                  rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_s = rst_pipe[RST_STAGES-1];

  // Decode and policy
  logic                             dec_hit;
  logic                             req_hit;
  acc_kind_e                        pol_kind;
  bank_e                            pol_bank;
  logic [DATA_W-1:0]                bank_rd;
  logic [NUM_BANKS-1:0][DATA_W-1:0] copy_q;

  tidb_decode u_decode (
    .cp  (req_cp),
    .op1 (req_op1),
    .crn (req_crn),
    .crm (req_crm),
    .op2 (req_op2),
    .hit (dec_hit)
  );

  tidb_policy u_policy (
    .el         (cur_el),
    .ns_bit     (ns_bit),
    .hyp_en     (hyp_en),
    .hyp_aa64   (hyp_aa64),
    .hyp_trap13 (hyp_trap13),
    .mon_impl   (mon_impl),
    .mon_aa32   (mon_aa32),
    .kind       (pol_kind),
    .bank       (pol_bank)
  );

  // Next state
  acc_kind_e         kind;
  logic              wr_en;
  logic              done_d, undef_d, t64_d, t32_d;
  logic [SYN_W-1:0]  syn_d;
  logic [DATA_W-1:0] rdata_d;

  always_comb begin
    req_hit = req_valid && dec_hit;
    kind    = req_hit ? pol_kind : ACC_NONE;
    wr_en   = (kind == ACC_DONE) && req_write;
    done_d  = (kind == ACC_DONE);
    undef_d = (kind == ACC_UNDEF);
    t64_d   = (kind == ACC_TRAP64);
    t32_d   = (kind == ACC_TRAP32);
    syn_d   = (t64_d || t32_d) ? SYN_HYP : '0;
    rdata_d = (done_d && !req_write) ? bank_rd : '0;
  end

  tidb_bank #(.DATA_W(DATA_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_en   (wr_en),
    .wr_bank (pol_bank),
    .wr_data (req_wdata),
    .rd_bank (pol_bank),
    .rd_data (bank_rd),
    .copy_q  (copy_q)
  );

  // Registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      done      <= 1'b0;
      undef_flt <= 1'b0;
      trap64    <= 1'b0;
      trap32    <= 1'b0;
      syndrome  <= '0;
      rdata     <= '0;
    end else begin
      done      <= done_d;
      undef_flt <= undef_d;
      trap64    <= t64_d;
      trap32    <= t32_d;
      syndrome  <= syn_d;
      rdata     <= rdata_d;
    end
  end

  // R7
  resp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0({done, undef_flt, trap64, trap32}));

  // R3
  trap_syn_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (trap64 || trap32) |-> (syndrome == SYN_HYP));

  // R8
  syn_idle_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(trap64 || trap32) |-> (syndrome == '0));

  // R2
  el0_undef_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (req_valid && dec_hit && cur_el == 2'd0) |=> undef_flt);

  // R1
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (req_valid && !dec_hit) |=> !(done || undef_flt || trap64 || trap32));

  // R5
  el2_sec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (req_valid && dec_hit && cur_el == 2'd2) |=> $stable(copy_q[BANK_SEC]));

  // R2 R3
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (req_valid && dec_hit && pol_kind != ACC_DONE) |=> $stable(copy_q));

endmodule

// File: tb/tidb_ctrl_bench.sv
module tidb_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int K_NONE = 0, K_DONE = 1, K_UNDEF = 2, K_T64 = 3, K_T32 = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [3:0]  req_cp, req_crn, req_crm;
  logic [2:0]  req_op1, req_op2;
  logic [31:0] req_wdata;
  logic [1:0]  cur_el;
  logic        ns_bit, hyp_en, hyp_aa64, hyp_trap13, mon_impl, mon_aa32;
  logic        done, undef_flt, trap64, trap32;
  logic [31:0] rdata;
  logic [7:0]  syndrome;

  always #(CLK_PERIOD/2) clk = ~clk;

  tidb_ctrl u_tidb_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_cp(req_cp), .req_op1(req_op1), .req_crn(req_crn), .req_crm(req_crm),
    .req_op2(req_op2), .req_wdata(req_wdata), .cur_el(cur_el), .ns_bit(ns_bit),
    .hyp_en(hyp_en), .hyp_aa64(hyp_aa64), .hyp_trap13(hyp_trap13),
    .mon_impl(mon_impl), .mon_aa32(mon_aa32), .done(done), .rdata(rdata),
    .undef_flt(undef_flt), .trap64(trap64), .trap32(trap32), .syndrome(syndrome)
  );

  typedef struct {
    int          kind;
    logic [31:0] data;
    int          tag;
  } exp_t;

  exp_t        sb_q[$];
  int          n_chk = 0;
  int          n_err = 0;
  bit          running = 1'b0;
  bit          finished = 1'b0;
  logic [31:0] mdl_sec, mdl_nsec;

  task automatic chk(input int tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL R%0d %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  // Expected outcome from the requirements (R1..R6, R9)
  task automatic access(input bit wr, input logic [1:0] el, input bit ns,
                        input logic [31:0] wd, input int tag,
                        input logic [3:0] cp = 4'hF, input logic [2:0] op1 = 3'h0,
                        input logic [3:0] crn = 4'hD, input logic [3:0] crm = 4'h0,
                        input logic [2:0] op2 = 3'h4);
    exp_t e;
    bit   use_ns;
    e.tag  = tag;
    e.data = '0;
    use_ns = 1'b1;
    if (!(cp == 4'hF && op1 == 3'h0 && crn == 4'hD && crm == 4'h0 && op2 == 3'h4)) begin
      e.kind = K_NONE;
    end else if (el == 2'd0) begin
      e.kind = K_UNDEF;
    end else if (el == 2'd1 && hyp_en && hyp_trap13) begin
      e.kind = hyp_aa64 ? K_T64 : K_T32;
    end else begin
      e.kind = K_DONE;
      if (el == 2'd3) use_ns = ns;
      else if (el == 2'd1 && mon_impl && mon_aa32) use_ns = ns;
      if (wr) begin
        if (use_ns) mdl_nsec = wd; else mdl_sec = wd;
      end else begin
        e.data = use_ns ? mdl_nsec : mdl_sec;
      end
    end
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; cur_el = el; ns_bit = ns; req_wdata = wd;
    req_cp = cp; req_op1 = op1; req_crn = crn; req_crm = crm; req_op2 = op2;
    sb_q.push_back(e);
  endtask

  task automatic cfg(input bit he, input bit h64, input bit t13, input bit mi, input bit m32);
    @(negedge clk);
    req_valid = 1'b0;
    hyp_en = he; hyp_aa64 = h64; hyp_trap13 = t13; mon_impl = mi; mon_aa32 = m32;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  // Monitor: pops one expected item per sampled request
  initial begin
    bit   sampled;
    exp_t e;
    forever begin
      @(posedge clk);
      sampled = running && req_valid;
      #(CLK_PERIOD/4);
      if (sampled) begin
        if (sb_q.size() == 0) begin
          chk(7, "unexpected request", 32'd1, 32'd0);
        end else begin
          e = sb_q.pop_front();
          chk(e.tag, "pulses {done,undef,t64,t32}", {28'd0, done, undef_flt, trap64, trap32},
              {28'd0, e.kind == K_DONE, e.kind == K_UNDEF, e.kind == K_T64, e.kind == K_T32});
          chk(e.tag, "rdata", rdata, e.data);
          if (e.kind == K_T64 || e.kind == K_T32) chk(3, "syndrome", {24'd0, syndrome}, 32'h03);
          else chk(8, "syndrome", {24'd0, syndrome}, 32'h0);
        end
      end else if (running) begin
        // R7: no pulse without a request
        chk(7, "idle outputs", {25'd0, done, undef_flt, trap64, trap32, |rdata, |syndrome, 1'b0}, 32'd0);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_wdata = '0;
    req_cp = '0; req_op1 = '0; req_crn = '0; req_crm = '0; req_op2 = '0;
    cur_el = '0; ns_bit = 1'b0;
    hyp_en = 1'b0; hyp_aa64 = 1'b0; hyp_trap13 = 1'b0; mon_impl = 1'b1; mon_aa32 = 1'b1;
    mdl_sec = 'x; mdl_nsec = 'x;
    repeat (3) @(negedge clk);
    // R10: outputs low in reset
    chk(10, "outputs in reset", {rdata[31:6], done, undef_flt, trap64, trap32, |syndrome, 1'b0}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10: outputs low after release
    chk(10, "outputs after reset", {rdata[31:6], done, undef_flt, trap64, trap32, |syndrome, 1'b0}, 32'd0);
    running = 1'b1;

    // R6: level 3 selects by ns_bit
    access(1'b1, 2'd3, 1'b0, 32'h1111_AAAA, 6);
    access(1'b1, 2'd3, 1'b1, 32'h2222_BBBB, 6);
    access(1'b0, 2'd3, 1'b0, 32'h0, 6);
    access(1'b0, 2'd3, 1'b1, 32'h0, 6);
    idle(1);

    // R2: level 0 faults, copies unchanged
    access(1'b1, 2'd0, 1'b0, 32'hBAD0_0000, 2);
    access(1'b0, 2'd0, 1'b1, 32'h0, 2);
    access(1'b0, 2'd3, 1'b0, 32'h0, 2);

    // R3: trap outputs and priority over banking
    cfg(1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    access(1'b1, 2'd1, 1'b0, 32'hBAD1_0000, 3);
    cfg(1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
    access(1'b1, 2'd1, 1'b1, 32'hBAD2_0000, 3);
    access(1'b0, 2'd1, 1'b0, 32'h0, 3);
    access(1'b0, 2'd3, 1'b0, 32'h0, 3);
    access(1'b0, 2'd3, 1'b1, 32'h0, 3);
    // R3: trap control without enabled level 2 does not trap
    cfg(1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    access(1'b0, 2'd1, 1'b1, 32'h0, 3);
    // R3: level 2 itself is never trapped
    cfg(1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    access(1'b0, 2'd2, 1'b0, 32'h0, 3);

    // R4: banked level 1
    cfg(1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    access(1'b1, 2'd1, 1'b0, 32'hC0C0_0001, 4);
    access(1'b1, 2'd1, 1'b1, 32'hD0D0_0002, 4);
    access(1'b0, 2'd3, 1'b0, 32'h0, 4);
    access(1'b0, 2'd3, 1'b1, 32'h0, 4);
    // R4: unbanked level 1 uses the non-secure storage
    cfg(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    access(1'b1, 2'd1, 1'b0, 32'hE0E0_0003, 4);
    access(1'b0, 2'd3, 1'b1, 32'h0, 4);
    access(1'b0, 2'd3, 1'b0, 32'h0, 4);
    cfg(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    access(1'b0, 2'd1, 1'b0, 32'h0, 4);

    // R5: level 2 uses the non-secure copy in every configuration
    cfg(1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    access(1'b1, 2'd2, 1'b0, 32'hF00D_0004, 5);
    access(1'b0, 2'd3, 1'b1, 32'h0, 5);
    access(1'b0, 2'd3, 1'b0, 32'h0, 5);
    cfg(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    access(1'b0, 2'd2, 1'b1, 32'h0, 5);

    // R1: each field wrong in turn, no response and no change
    cfg(1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    access(1'b1, 2'd3, 1'b0, 32'h5555_0001, 1, 4'hE);
    access(1'b1, 2'd3, 1'b0, 32'h5555_0002, 1, 4'hF, 3'h1);
    access(1'b1, 2'd3, 1'b0, 32'h5555_0003, 1, 4'hF, 3'h0, 4'hC);
    access(1'b1, 2'd3, 1'b1, 32'h5555_0004, 1, 4'hF, 3'h0, 4'hD, 4'h1);
    access(1'b1, 2'd3, 1'b1, 32'h5555_0005, 1, 4'hF, 3'h0, 4'hD, 4'h0, 3'h3);
    access(1'b0, 2'd3, 1'b0, 32'h0, 1);
    access(1'b0, 2'd3, 1'b1, 32'h0, 1);

    // R9: back-to-back write then read of the same copy
    access(1'b1, 2'd3, 1'b0, 32'h1234_5678, 9);
    access(1'b0, 2'd3, 1'b0, 32'h0, 9);
    access(1'b1, 2'd3, 1'b1, 32'h8765_4321, 9);
    access(1'b0, 2'd3, 1'b1, 32'h0, 9);
    access(1'b0, 2'd3, 1'b0, 32'h0, 9);

    idle(4);
    chk(7, "scoreboard drained", sb_q.size(), 32'd0);
    finish_run();
  end

endmodule